// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank

This block is a bank of general-purpose pins. Software reaches it through a word-addressed register port with single-cycle write and read strobes. Each pin can be an input or an output. Output levels and pin directions are changed only through separate set and clear strobe registers, so updating one pin never needs a read-modify-write of its neighbours. Every pin input passes through a two-flop synchronizer. A rising or falling transition on a pin can set a sticky per-pin status bit, and any set status bit raises the interrupt line. Software acknowledges a pin by writing a one to its bit in the acknowledge register.

A second pair of edge masks, separate from the interrupt masks, produces a one-cycle wake request pulse. Plain registers hold the per-pin sleep control, two alternate-function select bits and a pull-off bit, and each one drives its own output port. The two select bits are decoded into three one-hot alternate-mode outputs per pin. A parameter builds a reduced variant that has no wake, sleep or alternate-function storage.

Top module: `gpio_bank`

## Requirements
- R1: After reset every pin is an input (pin_oe = 0), pin_out = 0, and all masks and status bits are 0. As a result irq = 0, wake_req = 0, and reads of the direction, mask and status registers return 0.
- R2: A write to offset 1 (output set) drives high every pin_out bit whose write-data bit is 1. A write to offset 2 (output clear) drives low every pin_out bit whose write-data bit is 1. Bits written as 0 keep their value. The change is visible after the write's clock edge.
- R3: Offset 4 (direction set) and offset 5 (direction clear) use the same write-one rule on the direction state. pin_oe equals that state, and a read of offset 3 returns it, with 1 meaning output.
- R4: A read of offset 0 returns the pin_in levels after the two-flop synchronizer. Read data is registered: bus_rdata holds the value from the cycle the read strobe was sampled, so a pin change made one cycle before a read has not yet reached the result.
- R5: Offsets 6 and 7 are the read/write rising-edge and falling-edge interrupt masks. An edge on a pin sets that pin's status bit (read at offset 8) only if the matching mask bit is 1. Status bits stay set until they are acknowledged.
- R6: Writing 1 to a bit at offset 9 clears that status bit. If an enabled edge on the same pin arrives in the same cycle as the clear, the bit stays set.
- R7: irq is 1 exactly when at least one status bit is 1.
- R8: Offsets 10 and 11 are rising and falling wake masks, independent of the interrupt masks. An edge enabled by them makes wake_req high for one cycle, in the same cycle that an enabled edge would first appear in the status.
- R9: Offset 12 (sleep control) and offset 15 (pull off, 1 disables the pull) are read/write registers. They drive pin_sleep and pin_pull_dis.
- R10: Offsets 13 (select A) and 14 (select B) are read/write. For each pin, pin_alt_a = A and not B, pin_alt_b = B and not A, and pin_alt_c = A and B.
- R11: With HAS_EXTRAS = 0, offsets 10 through 14 read as 0 and ignore writes, and wake_req, pin_sleep and all alternate outputs stay 0. The data, direction and interrupt registers behave as in R2 to R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 4 | Word offset of the register |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wdata | input | NPINS | Write data, one bit per pin |
| bus_rdata | output | NPINS | Registered read data |
| pin_in | input | NPINS | Pin input levels |
| pin_out | output | NPINS | Output levels |
| pin_oe | output | NPINS | Output enables, 1 = output |
| pin_pull_dis | output | NPINS | Pull disable per pin |
| pin_sleep | output | NPINS | Sleep control per pin |
| pin_alt_a | output | NPINS | Alternate mode A selected |
| pin_alt_b | output | NPINS | Alternate mode B selected |
| pin_alt_c | output | NPINS | Alternate mode C selected |
| irq | output | 1 | Interrupt, OR of status bits |
| wake_req | output | 1 | One-cycle wake request pulse |

## Verification
A wrong output or direction bit shows on pin_out or pin_oe right after the offending write edge. It also shows in the direction read one cycle after the read strobe. A wrong edge-detector or status bit changes irq three clock edges after the pin moves, and shows in the status read. A collision between an edge and an acknowledge that is handled wrongly leaves the status bit clear where it should be set. Wake mask errors show on wake_req in that same third cycle, or as a pulse that lasts more than one cycle. The reduced build is driven in parallel on the same bus, so any stored wake or alternate bit in it shows up as a nonzero read or port.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int REG_AW   = 4;
  localparam int NUM_REGS = 1 << REG_AW;

  localparam logic [REG_AW-1:0] OFS_LEVEL     = 4'd0;
  localparam logic [REG_AW-1:0] OFS_OUT_SET   = 4'd1;
  localparam logic [REG_AW-1:0] OFS_OUT_CLR   = 4'd2;
  localparam logic [REG_AW-1:0] OFS_DIR       = 4'd3;
  localparam logic [REG_AW-1:0] OFS_DIR_SET   = 4'd4;
  localparam logic [REG_AW-1:0] OFS_DIR_CLR   = 4'd5;
  localparam logic [REG_AW-1:0] OFS_IRQ_RISE  = 4'd6;
  localparam logic [REG_AW-1:0] OFS_IRQ_FALL  = 4'd7;
  localparam logic [REG_AW-1:0] OFS_IRQ_STAT  = 4'd8;
  localparam logic [REG_AW-1:0] OFS_IRQ_ACK   = 4'd9;
  localparam logic [REG_AW-1:0] OFS_WAKE_RISE = 4'd10;
  localparam logic [REG_AW-1:0] OFS_WAKE_FALL = 4'd11;
  localparam logic [REG_AW-1:0] OFS_SLEEP     = 4'd12;
  localparam logic [REG_AW-1:0] OFS_SEL_A     = 4'd13;
  localparam logic [REG_AW-1:0] OFS_SEL_B     = 4'd14;
  localparam logic [REG_AW-1:0] OFS_PULL_OFF  = 4'd15;
endpackage

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign lvl_o  = sync_q;
  assign rise_o = sync_q & ~prev_q;
  assign fall_o = ~sync_q & prev_q;
endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o,
  output logic         irq_o
);
  logic [W-1:0] stat_q, stat_d;
  logic         stat_en;

  always_comb begin
    stat_en = (set_i != '0) || (clr_i != '0);
    stat_d  = (stat_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  assign stat_o = stat_q;
  assign irq_o  = |stat_q;

  AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_ni)
    (set_i != '0) |=> ((stat_q & $past(set_i)) == $past(set_i))); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((stat_q & $past(clr_i & ~set_i)) == '0)); // R6
  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> (($past(stat_q & ~clr_i) & ~stat_q) == '0)); // R5
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS      = 32,
  parameter bit HAS_EXTRAS = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  pin_pull_dis,
  output logic [NPINS-1:0]  pin_sleep,
  output logic [NPINS-1:0]  pin_alt_a,
  output logic [NPINS-1:0]  pin_alt_b,
  output logic [NPINS-1:0]  pin_alt_c,
  output logic              irq,
  output logic              wake_req
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // write decode
  logic [NUM_REGS-1:0] wsel;
  assign wsel = bus_wr ? (NUM_REGS'(1) << bus_addr) : '0;

  // core registers
  logic [NPINS-1:0] out_q, out_d, dir_q, dir_d;
  logic [NPINS-1:0] rise_q, fall_q, pull_q;
  logic             out_en, dir_en;

  always_comb begin
    out_en = wsel[OFS_OUT_SET] | wsel[OFS_OUT_CLR];
    dir_en = wsel[OFS_DIR_SET] | wsel[OFS_DIR_CLR];
    out_d  = out_q;
    if (wsel[OFS_OUT_SET]) out_d = out_d | bus_wdata;
    if (wsel[OFS_OUT_CLR]) out_d = out_d & ~bus_wdata;
    dir_d  = dir_q;
    if (wsel[OFS_DIR_SET]) dir_d = dir_d | bus_wdata;
    if (wsel[OFS_DIR_CLR]) dir_d = dir_d & ~bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      dir_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      pull_q <= '0;
    end else begin
      if (out_en)                 out_q  <= out_d;
      if (dir_en)                 dir_q  <= dir_d;
      if (wsel[OFS_IRQ_RISE])     rise_q <= bus_wdata;
      if (wsel[OFS_IRQ_FALL])     fall_q <= bus_wdata;
      if (wsel[OFS_PULL_OFF])     pull_q <= bus_wdata;
    end
  end

  // input path and interrupt status
  logic [NPINS-1:0] lvl, rise, fall, stat;

  gpio_sync_edge #(.W(NPINS)) u_sync (
    .clk(clk), .rst_ni(rst_ni), .d_i(pin_in),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  gpio_edge_status #(.W(NPINS)) u_stat (
    .clk(clk), .rst_ni(rst_ni),
    .set_i((rise & rise_q) | (fall & fall_q)),
    .clr_i(wsel[OFS_IRQ_ACK] ? bus_wdata : '0),
    .stat_o(stat), .irq_o(irq)
  );

  // optional wake, sleep and alternate-function storage
  logic [NPINS-1:0] wrise_q, wfall_q, sleep_q, sela_q, selb_q;
  logic             wake_q;

  if (HAS_EXTRAS) begin : g_extras
    logic wake_hit;
    assign wake_hit = |((rise & wrise_q) | (fall & wfall_q));

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        wrise_q <= '0;
        wfall_q <= '0;
        sleep_q <= '0;
        sela_q  <= '0;
        selb_q  <= '0;
        wake_q  <= 1'b0;
      end else begin
        if (wsel[OFS_WAKE_RISE]) wrise_q <= bus_wdata;
        if (wsel[OFS_WAKE_FALL]) wfall_q <= bus_wdata;
        if (wsel[OFS_SLEEP])     sleep_q <= bus_wdata;
        if (wsel[OFS_SEL_A])     sela_q  <= bus_wdata;
        if (wsel[OFS_SEL_B])     selb_q  <= bus_wdata;
        wake_q <= wake_hit;
      end
    end
  end else begin : g_lite
    assign wrise_q = '0;
    assign wfall_q = '0;
    assign sleep_q = '0;
    assign sela_q  = '0;
    assign selb_q  = '0;
    assign wake_q  = 1'b0;
  end

  // registered read port
  logic [NPINS-1:0] rd_mux, rdata_q;

  always_comb begin
    case (bus_addr)
      OFS_LEVEL:     rd_mux = lvl;
      OFS_DIR:       rd_mux = dir_q;
      OFS_IRQ_RISE:  rd_mux = rise_q;
      OFS_IRQ_FALL:  rd_mux = fall_q;
      OFS_IRQ_STAT:  rd_mux = stat;
      OFS_WAKE_RISE: rd_mux = wrise_q;
      OFS_WAKE_FALL: rd_mux = wfall_q;
      OFS_SLEEP:     rd_mux = sleep_q;
      OFS_SEL_A:     rd_mux = sela_q;
      OFS_SEL_B:     rd_mux = selb_q;
      OFS_PULL_OFF:  rd_mux = pull_q;
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata    = rdata_q;
  assign pin_out      = out_q;
  assign pin_oe       = dir_q;
  assign pin_pull_dis = pull_q;
  assign pin_sleep    = sleep_q;
  assign pin_alt_a    = sela_q & ~selb_q;
  assign pin_alt_b    = selb_q & ~sela_q;
  assign pin_alt_c    = sela_q & selb_q;
  assign wake_req     = wake_q;

  AST_OUT_SET_DRIVES: assert property (@(posedge clk) disable iff (!rst_ni)
    wsel[OFS_OUT_SET] |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata))); // R2
  AST_OUT_CLR_DRIVES: assert property (@(posedge clk) disable iff (!rst_ni)
    wsel[OFS_OUT_CLR] |=> ((pin_out & $past(bus_wdata)) == '0)); // R2
  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_ni)
    !(wsel[OFS_OUT_SET] || wsel[OFS_OUT_CLR]) |=> $stable(pin_out)); // R2
  AST_OE_HOLDS: assert property (@(posedge clk) disable iff (!rst_ni)
    !(wsel[OFS_DIR_SET] || wsel[OFS_DIR_CLR]) |=> $stable(pin_oe)); // R3
  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_ni)
    (wake_req && $stable(lvl)) |=> !wake_req); // R8
endmodule

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, pin_in;
  logic [31:0] bus_rdata, pin_out, pin_oe, pin_pull_dis, pin_sleep;
  logic [31:0] pin_alt_a, pin_alt_b, pin_alt_c;
  logic        irq, wake_req;
  logic [31:0] l_rdata, l_out, l_oe, l_pull, l_sleep, l_a, l_b, l_c;
  logic        l_irq, l_wake;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank #(.NPINS(32), .HAS_EXTRAS(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_pull_dis(pin_pull_dis), .pin_sleep(pin_sleep),
    .pin_alt_a(pin_alt_a), .pin_alt_b(pin_alt_b), .pin_alt_c(pin_alt_c),
    .irq(irq), .wake_req(wake_req)
  );

  gpio_bank #(.NPINS(32), .HAS_EXTRAS(1'b0)) dut_lite (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(l_rdata), .pin_in(pin_in), .pin_out(l_out),
    .pin_oe(l_oe), .pin_pull_dis(l_pull), .pin_sleep(l_sleep),
    .pin_alt_a(l_a), .pin_alt_b(l_b), .pin_alt_c(l_c),
    .irq(l_irq), .wake_req(l_wake)
  );

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [31:0] m_out, m_dir, m_rise, m_fall, m_stat, m_wr, m_wf;
  logic [31:0] m_sleep, m_sa, m_sb, m_pull, m_pins;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(logic [3:0] a);
    case (a)
      4'd0:  return m_pins;
      4'd3:  return m_dir;
      4'd6:  return m_rise;
      4'd7:  return m_fall;
      4'd8:  return m_stat;
      4'd10: return m_wr;
      4'd11: return m_wf;
      4'd12: return m_sleep;
      4'd13: return m_sa;
      4'd14: return m_sb;
      4'd15: return m_pull;
      default: return 32'h0;
    endcase
  endfunction

  task automatic bus_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    case (a)
      4'd1:  m_out = m_out | d;
      4'd2:  m_out = m_out & ~d;
      4'd4:  m_dir = m_dir | d;
      4'd5:  m_dir = m_dir & ~d;
      4'd6:  m_rise = d;
      4'd7:  m_fall = d;
      4'd9:  m_stat = m_stat & ~d;
      4'd10: m_wr = d;
      4'd11: m_wf = d;
      4'd12: m_sleep = d;
      4'd13: m_sa = d;
      4'd14: m_sb = d;
      4'd15: m_pull = d;
      default: ;
    endcase
  endtask

  task automatic bus_read(logic [3:0] a, output logic [31:0] d, output logic [31:0] ld);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata; ld = l_rdata;
  endtask

  task automatic set_pins(logic [31:0] v);
    logic [31:0] r, f;
    logic        ew;
    @(negedge clk);
    pin_in = v;
    r  = v & ~m_pins;
    f  = ~v & m_pins;
    ew = |((r & m_wr) | (f & m_wf));
    repeat (3) @(negedge clk);
    chk("R8 wake pulse", {31'b0, wake_req}, {31'b0, ew});
    chk("R11 lite wake", {31'b0, l_wake}, 32'h0);
    m_stat = m_stat | (r & m_rise) | (f & m_fall);
    m_pins = v;
    @(negedge clk);
    chk("R8 wake one cycle", {31'b0, wake_req}, 32'h0);
    chk("R7 irq", {31'b0, irq}, {31'b0, |m_stat});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, ld;
    void'($urandom(32'd24681357));
    rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0; pin_in = '0;
    m_out = 0; m_dir = 0; m_rise = 0; m_fall = 0; m_stat = 0; m_wr = 0; m_wf = 0;
    m_sleep = 0; m_sa = 0; m_sb = 0; m_pull = 0; m_pins = 0;
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", pin_oe, 32'h0);
    chk("R1 out in reset", pin_out, 32'h0);
    chk("R1 irq/wake in reset", {30'b0, irq, wake_req}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_read(4'd3, d, ld);  chk("R1 dir after reset", d, 32'h0);
    bus_read(4'd8, d, ld);  chk("R1 status after reset", d, 32'h0);
    bus_read(4'd6, d, ld);  chk("R1 rise mask after reset", d, 32'h0);
    bus_read(4'd10, d, ld); chk("R1 wake mask after reset", d, 32'h0);

    // R2 set/clear
    bus_write(4'd1, 32'hF0F0_00FF); chk("R2 set", pin_out, 32'hF0F0_00FF);
    bus_write(4'd2, 32'h0000_000F); chk("R2 clear", pin_out, 32'hF0F0_00F0);
    bus_write(4'd1, 32'h0);         chk("R2 zero write", pin_out, 32'hF0F0_00F0);

    // R3 direction
    bus_write(4'd4, 32'h8000_0001);
    bus_write(4'd5, 32'h0000_0001);
    bus_read(4'd3, d, ld); chk("R3 dir read", d, 32'h8000_0000);
    chk("R3 oe", pin_oe, 32'h8000_0000);

    // R4 level read and its latency
    set_pins(32'hA5A5_1234);
    bus_read(4'd0, d, ld); chk("R4 level", d, 32'hA5A5_1234);
    @(negedge clk); pin_in = 32'h0F0F_0000;
    bus_read(4'd0, d, ld); chk("R4 level not yet synced", d, 32'hA5A5_1234);
    bus_read(4'd0, d, ld); chk("R4 level synced", d, 32'h0F0F_0000);
    m_pins = 32'h0F0F_0000;
    repeat (2) @(negedge clk);

    // R5 masks
    set_pins(32'h0);
    bus_write(4'd6, 32'h1); bus_write(4'd7, 32'h2);
    set_pins(32'h7);
    bus_read(4'd8, d, ld); chk("R5 rise only pin0", d, 32'h1);
    set_pins(32'h0);
    bus_read(4'd8, d, ld); chk("R5 fall adds pin1", d, 32'h3);

    // R6 ack, then collision between an edge and an ack
    bus_write(4'd9, 32'h3);
    bus_read(4'd8, d, ld); chk("R6 ack clears", d, 32'h0);
    chk("R7 irq low after ack", {31'b0, irq}, 32'h0);
    bus_write(4'd7, 32'h3);
    set_pins(32'h1);
    @(negedge clk); pin_in = 32'h0;
    @(negedge clk);
    @(negedge clk); bus_addr = 4'd9; bus_wdata = 32'h1; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    m_pins = 32'h0;
    bus_read(4'd8, d, ld); chk("R6 edge wins over ack", d, 32'h1);
    bus_write(4'd9, 32'h1);
    bus_read(4'd8, d, ld); chk("R6 plain ack", d, 32'h0);
    m_stat = 0;

    // R8 wake independent of interrupt masks
    bus_write(4'd6, 32'h0); bus_write(4'd7, 32'h0);
    bus_write(4'd10, 32'h10); bus_write(4'd11, 32'h20);
    set_pins(32'h30);
    set_pins(32'h00);
    set_pins(32'h20);
    bus_read(4'd8, d, ld); chk("R8 wake sets no status", d, 32'h0);

    // R9, R10 plain registers and decode
    bus_write(4'd12, 32'hDEAD_BEEF); bus_write(4'd15, 32'h1234_5678);
    bus_write(4'd13, 32'h5); bus_write(4'd14, 32'h3);
    bus_read(4'd12, d, ld); chk("R9 sleep read", d, 32'hDEAD_BEEF);
    chk("R11 lite sleep read", ld, 32'h0);
    bus_read(4'd15, d, ld); chk("R9 pull read", d, 32'h1234_5678);
    chk("R9 ports", pin_sleep ^ pin_pull_dis, 32'hDEAD_BEEF ^ 32'h1234_5678);
    chk("R10 alt a", pin_alt_a, 32'h4);
    chk("R10 alt b", pin_alt_b, 32'h2);
    chk("R10 alt c", pin_alt_c, 32'h1);

    // R11 reduced variant
    bus_read(4'd13, d, ld); chk("R11 lite sel a", ld, 32'h0);
    bus_read(4'd10, d, ld); chk("R11 lite wake mask", ld, 32'h0);
    chk("R11 lite ports", l_sleep | l_a | l_b | l_c, 32'h0);
    chk("R11 lite pull", l_pull, 32'h1234_5678);
    bus_read(4'd3, d, ld); chk("R11 lite dir", ld, m_dir);

    // random phase
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 4);
      case (op)
        0: begin
          logic [3:0] a;
          case ($urandom_range(0, 6))
            0: a = 4'd1; 1: a = 4'd2; 2: a = 4'd4; 3: a = 4'd5;
            4: a = 4'd6; 5: a = 4'd7; default: a = 4'd9;
          endcase
          bus_write(a, $urandom());
          chk("R2 random out", pin_out, m_out);
          chk("R3 random oe", pin_oe, m_dir);
        end
        1: bus_write(4'($urandom_range(10, 15)), $urandom());
        2: set_pins(m_pins ^ ($urandom() & $urandom()));
        default: begin
          logic [3:0] a;
          a = 4'($urandom_range(0, 15));
          bus_read(a, d, ld);
          chk("R5 R9 random read", d, exp_read(a));
        end
      endcase
    end
    bus_read(4'd8, d, ld); chk("R5 final status", d, m_stat);
    chk("R11 lite status", ld, m_stat);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule